// File: doc/BRIEF.md
# SDRAM Bank Precharge Tracker

This block sits beside an SDRAM command scheduler and follows, for each of four banks, whether the bank is closed, open, waiting out an automatic or deferred precharge, or in the middle of closing. It watches the decoded command stream on its way to the memory: the command code, bank address and the A10/AP bit. From that stream it tells the scheduler which banks are idle and which banks may be given a new command. It also reports whether a precharge-all is safe, and whether every bank is idle, which the refresh logic needs.

Closing a bank is timed inside the block. Every open bank carries a row-active countdown that is loaded when the row opens. No precharge can begin until that countdown reaches zero, whether it was asked for explicitly or by a read or write with auto-precharge. After a read or write with AP high, the precharge start is also pushed back past the data burst. The burst length and CAS latency used for that come from two configuration inputs. Once a precharge begins, the bank returns to idle a fixed precharge time later.

Each bank runs one state machine with four states:
- `BK_IDLE`: the bank is closed.
- `BK_OPEN`: a row is active.
- `BK_HOLD`: a precharge has been requested and is waiting for the burst and the row-active time.
- `BK_PRECH`: the precharge is in progress.

The transitions are:
- **open** (`BK_IDLE` to `BK_OPEN`): on an activate.
- **hold on auto-precharge** (`BK_OPEN` to `BK_HOLD`): on a read or write with AP high.
- **hold on early close** (`BK_OPEN` to `BK_HOLD`): on a precharge issued before the row-active time has run out.
- **close now** (`BK_OPEN` to `BK_PRECH`): on a precharge issued once the row-active time has run out.
- **close** (`BK_HOLD` to `BK_PRECH`): when both the burst wait and the row-active countdown are zero.
- **done** (`BK_PRECH` to `BK_IDLE`): when the precharge countdown expires.

Top module: `sdram_bank_tracker`

## Requirements
- R1: While reset is low and in the cycle after it is released, every bank is idle and may accept a command, `all_idle_o` is 1 and `prea_ok_o` is 1.
- R2: The command code is 1 for activate, 2 for read, 3 for write and 4 for precharge; every other code is a no-op. An activate to an idle bank makes that bank not idle, but still able to accept commands, from the next cycle. An activate to a bank that is not idle is ignored and does not restart its row-active countdown.
- R3: A read or write with `a10_i` low leaves the bank open and able to accept commands for as long as no precharge arrives.
- R4: A precharge to a bank never starts earlier than T_RAS cycles after that bank's activate. A precharge issued earlier is deferred to exactly that cycle, and the bank refuses commands from the cycle after the request.
- R5: A bank becomes idle exactly T_RP cycles after its precharge starts. A precharge issued to an open bank whose row-active time has run out starts in the cycle it is issued.
- R6: A read with `a10_i` high issued in cycle e starts the precharge in cycle max(e + BL + CL, activate + T_RAS).
- R7: A write with `a10_i` high issued in cycle e starts the precharge in cycle max(e + BL + 1, activate + T_RAS). The extra cycle is write recovery.
- R8: The burst length BL is 1, 2, 4 or 8 for `cfg_bl_i` codes 0, 1, 2 and 3. The CAS latency CL is the value of `cfg_cl_i`.
- R9: A precharge with `a10_i` high (precharge-all) closes every open bank. A precharge with `a10_i` low closes only the bank selected by `ba_i`. Idle banks are not touched.
- R10: `prea_ok_o` is 1 exactly when every open bank has run out its row-active time. It becomes 1 in the cycle before a precharge may start, that is T_RAS-1 cycles after the last activate.
- R11: `all_idle_o` is the AND of the four per-bank idle flags.
- R12: After an auto-precharge or precharge request, the bank refuses commands until it is idle again. While it waits, any command addressed to it is ignored and leaves its idle time unchanged. Commands to other banks proceed normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 3 | Command issued this cycle: 0 none, 1 activate, 2 read, 3 write, 4 precharge |
| ba_i | input | 2 | Bank address of the command |
| a10_i | input | 1 | A10/AP bit: auto-precharge on read/write, all banks on precharge |
| cfg_bl_i | input | 2 | Burst length code: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8 |
| cfg_cl_i | input | 2 | CAS latency in cycles |
| bank_idle_o | output | 4 | Per-bank idle flag |
| bank_may_o | output | 4 | Per-bank flag: the bank may accept a new command |
| all_idle_o | output | 1 | All banks idle |
| prea_ok_o | output | 1 | A precharge-all may start in the next command cycle |

## Verification
Every output comes straight from registered state. A command sampled at edge e therefore shows its first effect on the flags after edge e. A precharge that starts at edge s shows the bank idle after edge s + T_RP, and `prea_ok_o` rises after edge activate + T_RAS - 1. The bench drives commands and samples outputs only on falling edges. It counts edges from the command's own edge: for each timed result it checks the cycle just before the due edge, expecting the old value, and the due edge itself, expecting the new value. An off-by-one in any countdown therefore shows up as a failed check.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_ACT   = 3'd1,
        OP_READ  = 3'd2,
        OP_WRITE = 3'd3,
        OP_PRE   = 3'd4
    } sdram_op_e;

    typedef enum logic [1:0] {
        BK_IDLE  = 2'd0,
        BK_OPEN  = 2'd1,
        BK_HOLD  = 2'd2,
        BK_PRECH = 2'd3
    } bank_state_e;

    localparam int unsigned MAX_BEATS = 8;
    localparam int unsigned MAX_CL    = 3;

    function automatic logic [3:0] burst_beats(input logic [1:0] code);
        return 4'd1 << code;
    endfunction

endpackage

// File: rtl/trk_cmd_decode.sv
module trk_cmd_decode
    import sdram_trk_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BA_W      = 2,
    parameter int CNT_W     = 4
) (
    input  logic [2:0]           cmd_i,
    input  logic [BA_W-1:0]      ba_i,
    input  logic                 a10_i,
    input  logic [1:0]           cfg_bl_i,
    input  logic [1:0]           cfg_cl_i,
    output logic [NUM_BANKS-1:0] act_o,
    output logic [NUM_BANKS-1:0] rw_o,
    output logic [NUM_BANKS-1:0] pre_o,
    output logic                 ap_o,
    output logic [CNT_W-1:0]     dly_o
);

    logic is_act, is_rd, is_wr, is_pre;
    logic [CNT_W-1:0] beats;

    always_comb begin
        is_act = 1'b0;
        is_rd  = 1'b0;
        is_wr  = 1'b0;
        is_pre = 1'b0;
        unique case (cmd_i)
            OP_ACT:   is_act = 1'b1;
            OP_READ:  is_rd  = 1'b1;
            OP_WRITE: is_wr  = 1'b1;
            OP_PRE:   is_pre = 1'b1;
            default:  ;
        endcase
    end

    // Delay from a read/write to the earliest precharge start
    always_comb begin
        beats = CNT_W'(burst_beats(cfg_bl_i));
        if (is_wr)
            dly_o = beats + CNT_W'(1);
        else
            dly_o = beats + CNT_W'(cfg_cl_i);
    end

    assign ap_o = a10_i;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_sel
        logic hit;
        assign hit      = (ba_i == BA_W'(b));
        assign act_o[b] = is_act && hit;
        assign rw_o[b]  = (is_rd || is_wr) && hit;
        assign pre_o[b] = is_pre && (a10_i || hit);
    end

endmodule

// File: rtl/trk_bank_fsm.sv
module trk_bank_fsm
    import sdram_trk_pkg::*;
#(
    parameter int T_RAS = 5,
    parameter int T_RP  = 3,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_i,
    input  logic             rw_i,
    input  logic             ap_i,
    input  logic             pre_i,
    input  logic [CNT_W-1:0] dly_i,
    output logic             idle_o,
    output logic             may_o,
    output logic             active_o,
    output logic             tras_met_o
);

    localparam logic [CNT_W-1:0] TRAS_LD = CNT_W'(T_RAS - 1);
    localparam logic [CNT_W-1:0] RP_LD   = CNT_W'(T_RP - 1);

    bank_state_e      st_q, st_d;
    logic [CNT_W-1:0] tras_q, tras_d;
    logic [CNT_W-1:0] wait_q, wait_d;
    logic [CNT_W-1:0] rp_q, rp_d;
    logic             tras_zero;

    assign tras_zero = (tras_q == '0);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= BK_IDLE;
            tras_q <= '0;
            wait_q <= '0;
            rp_q   <= '0;
        end else begin
            st_q   <= st_d;
            tras_q <= tras_d;
            wait_q <= wait_d;
            rp_q   <= rp_d;
        end
    end

    // Next state
    always_comb begin
        st_d   = st_q;
        tras_d = tras_zero ? '0 : tras_q - 1'b1;
        wait_d = wait_q;
        rp_d   = rp_q;
        unique case (st_q)
            BK_IDLE: begin
                if (act_i) begin
                    st_d   = BK_OPEN;
                    tras_d = TRAS_LD;
                end
            end
            BK_OPEN: begin
                if (pre_i) begin
                    if (tras_zero) begin
                        st_d = BK_PRECH;
                        rp_d = RP_LD;
                    end else begin
                        st_d   = BK_HOLD;
                        wait_d = '0;
                    end
                end else if (rw_i && ap_i) begin
                    st_d   = BK_HOLD;
                    wait_d = dly_i - 1'b1;
                end
            end
            BK_HOLD: begin
                if (wait_q == '0 && tras_zero) begin
                    st_d = BK_PRECH;
                    rp_d = RP_LD;
                end else if (wait_q != '0) begin
                    wait_d = wait_q - 1'b1;
                end
            end
            BK_PRECH: begin
                if (rp_q == '0)
                    st_d = BK_IDLE;
                else
                    rp_d = rp_q - 1'b1;
            end
        endcase
    end

    // Outputs
    always_comb begin
        idle_o   = 1'b0;
        may_o    = 1'b0;
        active_o = 1'b0;
        unique case (st_q)
            BK_IDLE:  begin idle_o = 1'b1; may_o = 1'b1; end
            BK_OPEN:  begin may_o = 1'b1; active_o = 1'b1; end
            BK_HOLD:  ;
            BK_PRECH: ;
        endcase
    end

    assign tras_met_o = tras_zero;

    AST_OPEN_FROM_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == BK_OPEN && $past(st_q) != BK_OPEN) |-> ($past(st_q) == BK_IDLE && $past(act_i))); // R2

    AST_TRAS_BEFORE_PRE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q == BK_PRECH) |-> ($past(tras_q) == '0)); // R4

    AST_IDLE_AFTER_PRECH: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == BK_IDLE && $past(st_q) != BK_IDLE) |-> ($past(st_q) == BK_PRECH)); // R5

    AST_HOLD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == BK_HOLD) |=> (st_q == BK_HOLD || st_q == BK_PRECH)); // R12

    AST_AP_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == BK_OPEN && rw_i && ap_i) |-> (dly_i != '0)); // R6

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
    import sdram_trk_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int T_RAS     = 5,
    parameter int T_RP      = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [2:0]                   cmd_i,
    input  logic [$clog2(NUM_BANKS)-1:0] ba_i,
    input  logic                         a10_i,
    input  logic [1:0]                   cfg_bl_i,
    input  logic [1:0]                   cfg_cl_i,
    output logic [NUM_BANKS-1:0]         bank_idle_o,
    output logic [NUM_BANKS-1:0]         bank_may_o,
    output logic                         all_idle_o,
    output logic                         prea_ok_o
);

    localparam int BA_W    = $clog2(NUM_BANKS);
    localparam int DLY_MAX = MAX_BEATS + MAX_CL + 1;
    localparam int T_MAX   = (T_RAS > T_RP) ? T_RAS : T_RP;
    localparam int CNT_MAX = (T_MAX > DLY_MAX) ? T_MAX : DLY_MAX;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic [NUM_BANKS-1:0] act_v, rw_v, pre_v;
    logic [NUM_BANKS-1:0] bank_active, bank_tras_met;
    logic                 ap;
    logic [CNT_W-1:0]     dly;

    trk_cmd_decode #(
        .NUM_BANKS (NUM_BANKS),
        .BA_W      (BA_W),
        .CNT_W     (CNT_W)
    ) u_decode (
        .cmd_i    (cmd_i),
        .ba_i     (ba_i),
        .a10_i    (a10_i),
        .cfg_bl_i (cfg_bl_i),
        .cfg_cl_i (cfg_cl_i),
        .act_o    (act_v),
        .rw_o     (rw_v),
        .pre_o    (pre_v),
        .ap_o     (ap),
        .dly_o    (dly)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        trk_bank_fsm #(
            .T_RAS (T_RAS),
            .T_RP  (T_RP),
            .CNT_W (CNT_W)
        ) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .act_i      (act_v[b]),
            .rw_i       (rw_v[b]),
            .ap_i       (ap),
            .pre_i      (pre_v[b]),
            .dly_i      (dly),
            .idle_o     (bank_idle_o[b]),
            .may_o      (bank_may_o[b]),
            .active_o   (bank_active[b]),
            .tras_met_o (bank_tras_met[b])
        );
    end

    assign all_idle_o = &bank_idle_o;
    assign prea_ok_o  = &(~bank_active | bank_tras_met);

    AST_PREA_CLOSES_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == OP_PRE && a10_i && prea_ok_o) |=> (bank_active == '0)); // R9

endmodule

// File: tb/test_sdram_bank_tracker.sv
module test_sdram_bank_tracker;

    localparam logic [2:0] C_NOP = 3'd0;
    localparam logic [2:0] C_ACT = 3'd1;
    localparam logic [2:0] C_RD  = 3'd2;
    localparam logic [2:0] C_WR  = 3'd3;
    localparam logic [2:0] C_PRE = 3'd4;

    // {is_write, bl_code, cl, gap after activate, cycles from r/w edge to idle}
    localparam int NVEC = 6;
    localparam logic [13:0] VEC [0:NVEC-1] = '{
        {1'b0, 2'd3, 2'd2, 4'd0, 5'd13},  // read, burst-bound
        {1'b0, 2'd0, 2'd2, 4'd0, 5'd7},   // read, row-active-bound
        {1'b1, 2'd2, 2'd2, 4'd0, 5'd8},   // write, burst+recovery-bound
        {1'b1, 2'd1, 2'd2, 4'd5, 5'd6},   // write late after activate
        {1'b0, 2'd2, 2'd3, 4'd2, 5'd10},  // read, CL 3
        {1'b1, 2'd0, 2'd2, 4'd0, 5'd7}    // write, row-active-bound
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cmd = C_NOP;
    logic [1:0] ba = 2'd0;
    logic       a10 = 1'b0;
    logic [1:0] cfg_bl = 2'd3;
    logic [1:0] cfg_cl = 2'd2;
    logic [3:0] idle, may;
    logic       all_idle, prea_ok;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sdram_bank_tracker i_sdram_bank_tracker (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_i       (cmd),
        .ba_i        (ba),
        .a10_i       (a10),
        .cfg_bl_i    (cfg_bl),
        .cfg_cl_i    (cfg_cl),
        .bank_idle_o (idle),
        .bank_may_o  (may),
        .all_idle_o  (all_idle),
        .prea_ok_o   (prea_ok)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive one command for one edge; returns at the falling edge after it
    task automatic issue(input logic [2:0] c, input logic [1:0] b, input logic a);
        cmd = c; ba = b; a10 = a;
        @(negedge clk);
        cmd = C_NOP; ba = 2'd0; a10 = 1'b0;
    endtask

    task automatic idle_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        idle_n(3);
        check("R1 idle in reset", {30'd0, all_idle, prea_ok}, 32'h3);
        check("R1 may in reset", {28'd0, may}, 32'hF);
        rst_n = 1'b1;
        idle_n(1);
        check("R1 idle after reset", {28'd0, idle}, 32'hF);
        check("R1 prea_ok after reset", {31'd0, prea_ok}, 32'h1);

        // Table: auto-precharge timing for reads (R6) and writes (R7), BL codes (R8)
        for (int i = 0; i < NVEC; i++) begin
            cfg_bl = VEC[i][12:11];
            cfg_cl = VEC[i][10:9];
            issue(C_ACT, 2'd1, 1'b0);
            idle_n(int'(VEC[i][8:5]));
            issue(VEC[i][13] ? C_WR : C_RD, 2'd1, 1'b1);
            check("R12 locked after auto-precharge", {31'd0, may[1]}, 32'h0);
            idle_n(int'(VEC[i][4:0]) - 1);
            check(VEC[i][13] ? "R7 not yet idle" : "R6 not yet idle", {31'd0, idle[1]}, 32'h0);
            idle_n(1);
            check(VEC[i][13] ? "R7 R8 idle on time" : "R6 R8 idle on time", {31'd0, idle[1]}, 32'h1);
        end
        cfg_bl = 2'd3;
        cfg_cl = 2'd2;

        // R2: activate, then second activate ignored (no countdown restart)
        issue(C_ACT, 2'd2, 1'b0);                // edge k
        check("R2 open", {30'd0, idle[2], may[2]}, 32'h1);
        issue(C_ACT, 2'd2, 1'b0);                // k+1, ignored
        idle_n(2);                               // after k+3
        check("R10 prea_ok low before tRAS", {31'd0, prea_ok}, 32'h0);
        idle_n(1);                               // after k+4
        check("R2 R10 prea_ok after tRAS-1", {31'd0, prea_ok}, 32'h1);
        // R5: explicit precharge with tRAS met at k+5
        issue(C_PRE, 2'd2, 1'b0);
        check("R5 busy after precharge", {31'd0, may[2]}, 32'h0);
        idle_n(2);
        check("R5 not idle at tRP-1", {31'd0, idle[2]}, 32'h0);
        idle_n(1);
        check("R5 idle at tRP", {31'd0, idle[2]}, 32'h1);

        // R4: early precharge deferred to activate + T_RAS
        issue(C_ACT, 2'd0, 1'b0);                // k
        issue(C_PRE, 2'd0, 1'b0);                // k+1
        check("R4 locked after early precharge", {31'd0, may[0]}, 32'h0);
        idle_n(5);                               // after k+6
        check("R4 not idle at k+7 side", {31'd0, idle[0]}, 32'h0);
        idle_n(1);                               // after k+7
        check("R4 not idle before start+tRP", {31'd0, idle[0]}, 32'h0);
        idle_n(1);                               // after k+8
        check("R4 idle at start+tRP", {31'd0, idle[0]}, 32'h1);

        // R3: read/write without AP keep bank open
        issue(C_ACT, 2'd1, 1'b0);
        issue(C_RD, 2'd1, 1'b0);
        issue(C_WR, 2'd1, 1'b0);
        idle_n(20);
        check("R3 still open", {30'd0, idle[1], may[1]}, 32'h1);
        issue(C_PRE, 2'd1, 1'b0);
        idle_n(3);
        check("R3 closed by precharge", {31'd0, idle[1]}, 32'h1);

        // R9/R10/R11: precharge-all
        issue(C_ACT, 2'd0, 1'b0);                // k
        issue(C_ACT, 2'd1, 1'b0);                // k+1
        idle_n(3);                               // after k+4
        check("R10 prea_ok waits for later bank", {31'd0, prea_ok}, 32'h0);
        idle_n(1);                               // after k+5
        check("R10 prea_ok when all met", {31'd0, prea_ok}, 32'h1);
        check("R11 all_idle low", {31'd0, all_idle}, 32'h0);
        issue(C_PRE, 2'd3, 1'b1);                // k+6
        check("R9 precharge-all busy set", {28'd0, may}, 32'hC);
        idle_n(2);
        check("R9 idle banks untouched", {28'd0, idle}, 32'hC);
        idle_n(1);
        check("R9 R11 all idle", {27'd0, idle, all_idle}, 32'h1F);

        // R9: single precharge selects by bank address
        issue(C_ACT, 2'd0, 1'b0);
        issue(C_ACT, 2'd1, 1'b0);
        idle_n(5);
        issue(C_PRE, 2'd1, 1'b0);
        idle_n(3);
        check("R9 selected bank closed, other open", {28'd0, idle}, 32'hE);
        check("R9 other bank still usable", {31'd0, may[0]}, 32'h1);
        issue(C_PRE, 2'd0, 1'b0);
        idle_n(3);

        // R12: commands to a locked bank are ignored; other banks proceed
        issue(C_ACT, 2'd3, 1'b0);                // k
        issue(C_RD, 2'd3, 1'b1);                 // e=k+1, BL8 CL2 -> idle at e+13
        issue(C_ACT, 2'd3, 1'b0);                // e+1
        issue(C_PRE, 2'd3, 1'b0);                // e+2
        issue(C_RD, 2'd3, 1'b0);                 // e+3
        issue(C_ACT, 2'd0, 1'b0);                // e+4
        check("R12 other bank opened", {30'd0, idle[0], may[0]}, 32'h1);
        idle_n(8);                               // after e+12
        check("R12 locked bank not yet idle", {31'd0, idle[3]}, 32'h0);
        idle_n(1);                               // after e+13
        check("R12 locked bank idle unchanged", {31'd0, idle[3]}, 32'h1);
        issue(C_PRE, 2'd0, 1'b0);
        idle_n(3);
        check("R11 all idle at end", {31'd0, all_idle}, 32'h1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule